// File: doc/BRIEF.md
# SDRAM Dynamic Power-Down Sequencer

This block sits beside the command scheduler of an SDRAM controller and handles power saving on the memory side. It drives the clock-enable (CKE) pin and an enable for the external memory clock. It does this from two configuration bits and an interface-idle flag that the scheduler supplies. When power-down is enabled, CKE drops on every cycle in which the memory interface is idle and no command waits. When clock disabling is in effect, the external clock stops under the same condition. A pending command raises CKE and restarts the clock in the same cycle, so enabling these modes costs the access no latency.

The block also decides when stalled accesses may proceed after the controller leaves its idle state. In SDR mode they proceed at once. In DDR fixed-delay mode they wait until a programmable initial-latency count has run out. A change to the clock-disable bit is never applied in the middle of traffic. It is held until the interface is idle.

Top module: `sdram_pwr_seq`

## Requirements
- R1: While reset is asserted and directly after it, `cke` is 1, `extClkEn` is 1, `stallRelease` is 0, the clock-disable setting in effect is clear and the latency counter is 0.
- R2: In a cycle where `ifIdle` is 1 and `cmdPending` is 0 (an idle cycle), `cke` is 0 if `cfgPwrDnEn` is 1. When `cfgPwrDnEn` is 0, `cke` stays 1 in every cycle.
- R3: In any cycle where `cmdPending` is 1 or `ifIdle` is 0, `cke` and `extClkEn` are both 1 in that same cycle, with no added latency.
- R4: In an idle cycle, `extClkEn` is 0 exactly when the clock-disable setting in effect is 1. With power-down on and clock-disable off, `extClkEn` stays 1 while `cke` is 0.
- R5: The setting in effect takes the value of `cfgExtClkDisReq` only at the end of an idle cycle. A change made during busy cycles is held, and the new value first shows in the cycle after the next idle cycle.
- R6: With `cfgDdrMode` at 0 (SDR), `stallRelease` equals 1 in every cycle where `ctrlIdle` is 0, including the first such cycle.
- R7: With `cfgDdrMode` at 1 (DDR fixed delay), the cycles after leaving the idle state are numbered k = 0, 1, 2, and so on. `stallRelease` is 1 in cycle k exactly when k >= `cfgInitLat`. It is 0 whenever `ctrlIdle` is 1, and each return to idle restarts the count.
- R8: In DDR mode a `cfgInitLat` of 0 releases in cycle k=0. The count saturates at 2^LAT_W-1, so a release that has been reached stays asserted for as long as the controller stays out of idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPwrDnEn | input | 1 | Enable CKE power-down on idle cycles |
| cfgExtClkDisReq | input | 1 | Requested setting for stopping the external clock on idle cycles |
| cfgDdrMode | input | 1 | 0 = SDR immediate release, 1 = DDR fixed-delay release |
| cfgInitLat | input | LAT_W | Initial latency in cycles for DDR release |
| ifIdle | input | 1 | Memory interface has no access in progress |
| cmdPending | input | 1 | A new memory command is waiting to issue |
| ctrlIdle | input | 1 | Controller is in its idle state |
| cke | output | 1 | Memory clock-enable pin |
| extClkEn | output | 1 | Enable for the external memory clock |
| stallRelease | output | 1 | Stalled accesses may proceed |

## Verification
The bench builds the block with LAT_W = 4. That keeps the full latency range, 0 to 15, within a few cycles of one another. It covers the zero-latency case, a mid-range value of 3 and the saturating maximum of 15 all in one run. A narrow counter also means the saturation point is reached and then held for several extra cycles, which would take too long to observe with a wide counter.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
  typedef struct packed {
    logic idleNow;     // interface idle and nothing pending
    logic loadClkCfg;  // sample the clock-disable request
    logic latClear;    // controller idle: restart latency count
    logic latStep;     // controller active: advance latency count
  } pwrStrobes_t;
endpackage

// File: rtl/sdram_pwr_ctrl.sv
module sdram_pwr_ctrl
  import sdram_pwr_pkg::*;
(
  input  logic        ifIdle,
  input  logic        cmdPending,
  input  logic        ctrlIdle,
  output pwrStrobes_t strobes
);
  always_comb begin
    strobes.idleNow    = ifIdle && !cmdPending;
    strobes.loadClkCfg = ifIdle && !cmdPending;
    strobes.latClear   = ctrlIdle;
    strobes.latStep    = !ctrlIdle;
  end
endmodule

// File: rtl/sdram_pwr_dp.sv
module sdram_pwr_dp
  import sdram_pwr_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwrStrobes_t      strobes,
  input  logic             cfgPwrDnEn,
  input  logic             cfgExtClkDisReq,
  input  logic             cfgDdrMode,
  input  logic [LAT_W-1:0] cfgInitLat,
  input  logic             cmdPending,
  input  logic             ctrlIdle,
  output logic             cke,
  output logic             extClkEn,
  output logic             stallRelease
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  logic             clkDisEff;
  logic [LAT_W-1:0] latCnt;
  logic             latDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkDisEff <= 1'b0;
    else if (strobes.loadClkCfg) clkDisEff <= cfgExtClkDisReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latCnt <= '0;
    else if (strobes.latClear) latCnt <= '0;
    else if (strobes.latStep && latCnt != LAT_MAX) latCnt <= latCnt + 1'b1;
  end

  assign latDone = latCnt >= cfgInitLat;

  always_comb begin
    cke          = !(rstN && cfgPwrDnEn && strobes.idleNow);
    extClkEn     = !(rstN && clkDisEff && strobes.idleNow);
    stallRelease = rstN && !ctrlIdle && (!cfgDdrMode || latDone);
  end

  // R3
  cmd_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending |-> (cke && extClkEn));
  // R2
  pwrdn_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPwrDnEn |-> cke);
  // R5
  clk_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadClkCfg) |-> $stable(clkDisEff));
  // R6
  sdr_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDdrMode && !ctrlIdle) |-> stallRelease);
  // R7
  idle_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIdle |-> !stallRelease);
  // R8
  lat_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latCnt == LAT_MAX && !ctrlIdle) |=> (latCnt == LAT_MAX || $past(ctrlIdle)));
endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgPwrDnEn,
  input  logic             cfgExtClkDisReq,
  input  logic             cfgDdrMode,
  input  logic [LAT_W-1:0] cfgInitLat,
  input  logic             ifIdle,
  input  logic             cmdPending,
  input  logic             ctrlIdle,
  output logic             cke,
  output logic             extClkEn,
  output logic             stallRelease
);
  pwrStrobes_t strobes;

  sdram_pwr_ctrl u_ctrl (
    .ifIdle(ifIdle), .cmdPending(cmdPending), .ctrlIdle(ctrlIdle), .strobes(strobes)
  );

  sdram_pwr_dp #(.LAT_W(LAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgPwrDnEn(cfgPwrDnEn), .cfgExtClkDisReq(cfgExtClkDisReq),
    .cfgDdrMode(cfgDdrMode), .cfgInitLat(cfgInitLat),
    .cmdPending(cmdPending), .ctrlIdle(ctrlIdle),
    .cke(cke), .extClkEn(extClkEn), .stallRelease(stallRelease)
  );
endmodule

// File: tb/sdram_pwr_seq_test.sv
`timescale 1ns/100ps
module sdram_pwr_seq_test;
  localparam int LAT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPwrDnEn = 1'b0, cfgExtClkDisReq = 1'b0, cfgDdrMode = 1'b0;
  logic [LAT_W-1:0] cfgInitLat = '0;
  logic ifIdle = 1'b0, cmdPending = 1'b0, ctrlIdle = 1'b1;
  logic cke, extClkEn, stallRelease;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_pwr_seq #(.LAT_W(LAT_W)) uut (
    .clk(clk), .rstN(rstN), .cfgPwrDnEn(cfgPwrDnEn), .cfgExtClkDisReq(cfgExtClkDisReq),
    .cfgDdrMode(cfgDdrMode), .cfgInitLat(cfgInitLat), .ifIdle(ifIdle),
    .cmdPending(cmdPending), .ctrlIdle(ctrlIdle), .cke(cke), .extClkEn(extClkEn),
    .stallRelease(stallRelease)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance to the next falling edge, then settle
  task automatic step();
    @(negedge clk); #0.5;
  endtask

  task automatic test_reset();
    #0.5;
    check("R1 cke in reset", cke, 1'b1);
    check("R1 extClkEn in reset", extClkEn, 1'b1);
    check("R1 release in reset", stallRelease, 1'b0);
    @(negedge clk); rstN = 1'b1; #0.5;
    ifIdle = 1'b1; cfgExtClkDisReq = 1'b0; #0.5;
    check("R1 clock enabled after reset (setting clear)", extClkEn, 1'b1);
  endtask

  task automatic test_pwrdn();
    @(negedge clk); cfgPwrDnEn = 1'b1; ifIdle = 1'b1; cmdPending = 1'b0; #0.5;
    check("R2 cke low when idle", cke, 1'b0);
    check("R4 clock free-running with cke low", extClkEn, 1'b1);
    cmdPending = 1'b1; #0.5;
    check("R3 cke raised same cycle as pending", cke, 1'b1);
    cmdPending = 1'b0; ifIdle = 1'b0; #0.5;
    check("R3 cke high when busy", cke, 1'b1);
    cfgPwrDnEn = 1'b0; ifIdle = 1'b1; #0.5;
    check("R2 cke high with power-down off", cke, 1'b1);
  endtask

  task automatic test_clkdis();
    @(negedge clk); cfgExtClkDisReq = 1'b1; ifIdle = 1'b1; cmdPending = 1'b0; #0.5;
    check("R5 old setting in first idle cycle", extClkEn, 1'b1);
    step();
    check("R4 clock stopped when idle", extClkEn, 1'b0);
    cmdPending = 1'b1; #0.5;
    check("R3 clock restarted same cycle", extClkEn, 1'b1);
    cmdPending = 1'b0; ifIdle = 1'b0; cfgExtClkDisReq = 1'b0;
    step(); step(); step();
    check("R3 clock on while busy", extClkEn, 1'b1);
    ifIdle = 1'b1; #0.5;
    check("R5 busy-time change held", extClkEn, 1'b0);
    step();
    check("R5 change applied after idle cycle", extClkEn, 1'b1);
  endtask

  task automatic test_sdr();
    @(negedge clk); cfgDdrMode = 1'b0; ctrlIdle = 1'b1; #0.5;
    check("R6 no release while idle", stallRelease, 1'b0);
    ctrlIdle = 1'b0; #0.5;
    check("R6 immediate release in SDR", stallRelease, 1'b1);
    step();
    check("R6 release held in SDR", stallRelease, 1'b1);
    ctrlIdle = 1'b1; step();
  endtask

  task automatic run_ddr(input int lat, input int span);
    @(negedge clk); cfgDdrMode = 1'b1; cfgInitLat = lat[LAT_W-1:0]; ctrlIdle = 1'b1;
    step();
    ctrlIdle = 1'b0; #0.5;
    for (int k = 0; k < span; k++) begin
      if (lat == 0 || lat == 15) check("R8 DDR release edge case", stallRelease, k >= lat);
      else check("R7 DDR release timing", stallRelease, k >= lat);
      step();
    end
    ctrlIdle = 1'b1; #0.5;
    check("R7 release dropped on idle", stallRelease, 1'b0);
  endtask

  initial begin
    test_reset();
    test_pwrdn();
    test_clkdis();
    test_sdr();
    run_ddr(3, 6);
    run_ddr(3, 2);  // restart after return to idle
    run_ddr(0, 2);
    run_ddr(15, 20);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule